// File: doc/BRIEF.md
# Hiccup Soft-Start Supervisor for Paired Linear Regulators

This block sequences the start-up of two linear regulators that share a single soft-start reference ramp. The upstream switching regulator's in-regulation signal drives `enable`. While it is high, the supervisor produces a digital ramp code in millivolts. The code starts at zero and climbs in fixed steps to the reference target. Two external regulators follow this code. Each regulator's output is sampled into a millivolt feedback code that returns to the block.

During the ramp, each feedback code is compared against the ramp value. If either rail falls more than a set margin below the ramp, the supervisor treats it as a short or a failing supply. It then drops both regulator enables for one tick interval, clears the ramp and starts again; this restart is a hiccup. When the ramp has reached the target and both feedbacks lie within a tolerance of it, the supervisor raises its in-regulation flag and stops checking for shortfalls. A saturating counter reports how many hiccups have happened since the current enable session began.

All pins are plain levels sampled on the clock. No port carries a data stream, so no port has valid/ready handshaking or back-pressure. The feedback codes are taken as they stand on every clock edge. The default tick interval is 188 cycles at 100 MHz, which gives a 1.5 ms ramp from 0 to 800 mV.

Top module: `ssv_softstart_supervisor`

## Requirements
- R1: After reset, `ramp_mv`, `hiccup_cnt`, `rail_en_a`, `rail_en_b` and `in_reg` are all 0.
- R2: Take the first clock edge at which `enable` is sampled high while idle as edge 1. At edge n of an unfaulted ramp, `ramp_mv` equals min(REF_MV, floor((n-1)/TICK_CYCLES)*STEP_MV) and both rail enables are 1.
- R3: `ramp_mv` never exceeds REF_MV, and once it reaches REF_MV it stays there.
- R4: A rail is short when its feedback plus FAULT_MARGIN_MV is strictly less than `ramp_mv`. A feedback exactly FAULT_MARGIN_MV below the ramp is not a fault. A short seen during the ramp makes both enables 0 and `ramp_mv` 0 at the next edge.
- R5: After a hiccup, both enables stay 0 for exactly TICK_CYCLES edges. The ramp then restarts from 0 with both enables 1, so one hiccup period is (kf+1)*TICK_CYCLES+1 edges long, where kf = floor(FAULT_MARGIN_MV/STEP_MV)+1.
- R6: A short on rail A alone or on rail B alone triggers the same hiccup on both rails.
- R7: `in_reg` rises at the edge after a cycle in which `ramp_mv` equals REF_MV and both feedbacks are at least REF_MV-REG_TOL_MV. If the feedbacks are short of that window but not in fault, the ramp holds at REF_MV with `in_reg` 0 and no hiccup.
- R8: While `in_reg` is 1, feedback shortfalls are ignored: `in_reg`, both enables and `ramp_mv` = REF_MV hold, and `hiccup_cnt` does not change.
- R9: `hiccup_cnt` increments by one per hiccup and saturates at 2^CNT_W-1. It keeps its value while idle and clears at the edge that starts a new session.
- R10: When `enable` is sampled low, the next edge gives `ramp_mv` 0, both enables 0 and `in_reg` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Upstream switcher in regulation; starts and holds a session |
| fb_a_mv | input | CODE_W | Sampled feedback of rail A, millivolts |
| fb_b_mv | input | CODE_W | Sampled feedback of rail B, millivolts |
| ramp_mv | output | CODE_W | Shared soft-start reference code, millivolts |
| rail_en_a | output | 1 | Enable of regulator A |
| rail_en_b | output | 1 | Enable of regulator B |
| in_reg | output | 1 | Both rails in regulation; hiccup checking off |
| hiccup_cnt | output | CNT_W | Saturating hiccup count for this session |

## Verification
The embedded properties check on every cycle that the ramp stays bounded and moves only in single steps or back to zero. They also check that a detected short clears the ramp and both enables at the next edge, that a low enable forces idle, that the regulated state holds, and that the two enables always match. The exact cycle arithmetic is shown only by the bench's scenarios, which compare every cycle against closed-form expressions. That arithmetic covers the ramp slope, the hold length after a hiccup, the hiccup period, counter saturation and its clear on a new session. It also covers the margin boundary, the wait at the target with the tolerance edge, and the immunity to faults once in regulation.

// File: rtl/ssv_pkg.sv
`timescale 1ns/1ps
package ssv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_HOLD = 2'd2,
    ST_REG  = 2'd3
  } ssv_state_e;

  localparam int unsigned NUM_RAILS = 2;
endpackage

// File: rtl/ssv_tick_timer.sv
`timescale 1ns/1ps
module ssv_tick_timer #(
  parameter int unsigned TICK_CYCLES = 188
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run) begin
      if (tick) cnt_q <= '0;
      else      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: the interval counter never passes its last value
  p_tick_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/ssv_ramp_gen.sv
`timescale 1ns/1ps
module ssv_ramp_gen #(
  parameter int unsigned CODE_W  = 10,
  parameter int unsigned REF_MV  = 800,
  parameter int unsigned STEP_MV = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [CODE_W-1:0] ramp
);
  localparam int unsigned EW = CODE_W + 1;
  localparam logic [EW-1:0] REF_E  = EW'(REF_MV);
  localparam logic [EW-1:0] STEP_E = EW'(STEP_MV);

  logic [EW-1:0]     sum_e;
  logic [CODE_W-1:0] next_up;

  always_comb begin
    sum_e = {1'b0, ramp} + STEP_E;
    if (sum_e >= REF_E) next_up = REF_E[CODE_W-1:0];
    else                next_up = sum_e[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ramp <= '0;
    else if (clr) ramp <= '0;
    else if (adv) ramp <= next_up;
  end

  // R3: ramp is bounded by the reference code
  p_ramp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ramp} <= REF_E);

  // R2: a change of the ramp is a return to zero or a rise of at most one step
  p_ramp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp != $past(ramp) && ramp != '0) |->
      (ramp > $past(ramp) && ({1'b0, ramp} - {1'b0, $past(ramp)}) <= STEP_E));
endmodule

// File: rtl/ssv_rail_monitor.sv
`timescale 1ns/1ps
module ssv_rail_monitor #(
  parameter int unsigned CODE_W          = 10,
  parameter int unsigned REF_MV          = 800,
  parameter int unsigned FAULT_MARGIN_MV = 100,
  parameter int unsigned REG_TOL_MV      = 20
) (
  input  logic [CODE_W-1:0] fb,
  input  logic [CODE_W-1:0] ramp,
  output logic              short_det,
  output logic              at_target
);
  localparam int unsigned EW = CODE_W + 2;
  localparam logic [EW-1:0] MARGIN_E = EW'(FAULT_MARGIN_MV);
  localparam logic [EW-1:0] FLOOR_E  =
    (REG_TOL_MV >= REF_MV) ? '0 : EW'(REF_MV - REG_TOL_MV);

  logic [EW-1:0] fb_e;
  logic [EW-1:0] ramp_e;

  always_comb begin
    fb_e      = EW'(fb);
    ramp_e    = EW'(ramp);
    short_det = (fb_e + MARGIN_E) < ramp_e;
    at_target = fb_e >= FLOOR_E;
  end
endmodule

// File: rtl/ssv_hiccup_ctr.sv
`timescale 1ns/1ps
module ssv_hiccup_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (clr)                    count <= '0;
    else if (inc && count != CMAX)   count <= count + 1'b1;
  end

  // R9: a saturated count stays saturated unless a new session clears it
  p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX && !clr) |=> count == CMAX);

  // R9: the count moves by at most one per edge unless cleared
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count) && count != '0) |-> count == $past(count) + 1'b1);
endmodule

// File: rtl/ssv_softstart_supervisor.sv
`timescale 1ns/1ps
module ssv_softstart_supervisor
  import ssv_pkg::*;
#(
  parameter int unsigned CODE_W          = 10,
  parameter int unsigned REF_MV          = 800,
  parameter int unsigned STEP_MV         = 1,
  parameter int unsigned TICK_CYCLES     = 188,
  parameter int unsigned FAULT_MARGIN_MV = 100,
  parameter int unsigned REG_TOL_MV      = 20,
  parameter int unsigned CNT_W           = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CODE_W-1:0] fb_a_mv,
  input  logic [CODE_W-1:0] fb_b_mv,
  output logic [CODE_W-1:0] ramp_mv,
  output logic              rail_en_a,
  output logic              rail_en_b,
  output logic              in_reg,
  output logic [CNT_W-1:0]  hiccup_cnt
);
  localparam logic [CODE_W-1:0] REF_CODE = CODE_W'(REF_MV);

  ssv_state_e state_q, state_d;

  logic [NUM_RAILS-1:0][CODE_W-1:0] fb_vec;
  logic [NUM_RAILS-1:0]             short_vec;
  logic [NUM_RAILS-1:0]             ok_vec;
  logic any_short, all_ok, at_ref, tick;
  logic timer_run, timer_clr, ramp_clr, ramp_adv, cnt_clr, cnt_inc;

  assign fb_vec[0] = fb_a_mv;
  assign fb_vec[1] = fb_b_mv;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    ssv_rail_monitor #(
      .CODE_W(CODE_W), .REF_MV(REF_MV),
      .FAULT_MARGIN_MV(FAULT_MARGIN_MV), .REG_TOL_MV(REG_TOL_MV)
    ) i_mon (
      .fb(fb_vec[g]), .ramp(ramp_mv),
      .short_det(short_vec[g]), .at_target(ok_vec[g])
    );
  end

  assign any_short = |short_vec;
  assign all_ok    = &ok_vec;
  assign at_ref    = (ramp_mv == REF_CODE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (enable) state_d = ST_RAMP;
      ST_RAMP: begin
        if (!enable)               state_d = ST_IDLE;
        else if (any_short)        state_d = ST_HOLD;
        else if (at_ref && all_ok) state_d = ST_REG;
      end
      ST_HOLD: begin
        if (!enable)   state_d = ST_IDLE;
        else if (tick) state_d = ST_RAMP;
      end
      ST_REG:  if (!enable) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign timer_run = (state_q == ST_RAMP) || (state_q == ST_HOLD);
  assign timer_clr = (state_d != state_q);
  assign ramp_clr  = (state_d == ST_IDLE) || (state_d == ST_HOLD);
  assign ramp_adv  = (state_q == ST_RAMP) && (state_d == ST_RAMP) && tick;
  assign cnt_clr   = (state_q == ST_IDLE) && enable;
  assign cnt_inc   = (state_q == ST_RAMP) && (state_d == ST_HOLD);

  ssv_tick_timer #(.TICK_CYCLES(TICK_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .clr(timer_clr), .tick(tick)
  );

  ssv_ramp_gen #(.CODE_W(CODE_W), .REF_MV(REF_MV), .STEP_MV(STEP_MV)) i_ramp (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .adv(ramp_adv), .ramp(ramp_mv)
  );

  ssv_hiccup_ctr #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .count(hiccup_cnt)
  );

  assign rail_en_a = (state_q == ST_RAMP) || (state_q == ST_REG);
  assign rail_en_b = rail_en_a;
  assign in_reg    = (state_q == ST_REG);

  // R4: a short seen while ramping clears the ramp and both enables next edge
  p_short_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en_a && !in_reg && enable && any_short) |=>
      (ramp_mv == '0 && !rail_en_a && !rail_en_b));

  // R10: a low enable leads to idle outputs at the next edge
  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ramp_mv == '0 && !rail_en_a && !rail_en_b && !in_reg));

  // R8: regulation holds regardless of feedback while enabled
  p_reg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reg && enable) |=>
      (in_reg && rail_en_a && rail_en_b && ramp_mv == REF_CODE &&
       hiccup_cnt == $past(hiccup_cnt)));

  // R7: regulation is entered only from a full ramp with both rails in window
  p_reg_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_reg) |-> ($past(ramp_mv) == REF_CODE && $past(all_ok)));

  // R6: the two rails are always switched together
  p_en_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rail_en_a == rail_en_b);
endmodule

// File: tb/test_ssv_softstart_supervisor.sv
`timescale 1ns/1ps
module test_ssv_softstart_supervisor;
  localparam int CODE_W = 10;
  localparam int REF    = 40;
  localparam int STEP   = 1;
  localparam int T      = 3;
  localparam int M      = 10;
  localparam int TOL    = 5;
  localparam int CNT_W  = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int KF     = M / STEP + 1;
  localparam int P      = KF * T + T + 1;
  localparam int NSTEPS = (REF + STEP - 1) / STEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic trk_a = 1'b1, trk_b = 1'b1;
  logic [CODE_W-1:0] cst_a = '0, cst_b = '0;
  logic [CODE_W-1:0] fb_a_mv, fb_b_mv, ramp_mv;
  logic rail_en_a, rail_en_b, in_reg;
  logic [CNT_W-1:0] hiccup_cnt;

  int nchecks = 0;
  int nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign fb_a_mv = trk_a ? ramp_mv : cst_a;
  assign fb_b_mv = trk_b ? ramp_mv : cst_b;

  ssv_softstart_supervisor #(
    .CODE_W(CODE_W), .REF_MV(REF), .STEP_MV(STEP), .TICK_CYCLES(T),
    .FAULT_MARGIN_MV(M), .REG_TOL_MV(TOL), .CNT_W(CNT_W)
  ) i_ssv_softstart_supervisor (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .fb_a_mv(fb_a_mv), .fb_b_mv(fb_b_mv), .ramp_mv(ramp_mv),
    .rail_en_a(rail_en_a), .rail_en_b(rail_en_b), .in_reg(in_reg),
    .hiccup_cnt(hiccup_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // hiccup model: n counts edges from the session start (edge 1)
  task automatic sweep_fault(input string req, input int ncyc);
    for (int n = 1; n <= ncyc; n++) begin
      int ph, en_e, r_e, c_e;
      @(negedge clk);
      ph   = (n - 1) % P;
      en_e = (ph <= KF * T) ? 1 : 0;
      r_e  = en_e ? min2(REF, (ph / T) * STEP) : 0;
      c_e  = min2((n - 1) / P + ((ph > KF * T) ? 1 : 0), CMAX);
      chk({req, " en_a R5"}, int'(rail_en_a), en_e);
      chk({req, " en_b R6"}, int'(rail_en_b), en_e);
      chk({req, " ramp R4"}, int'(ramp_mv), r_e);
      chk({req, " cnt R9"}, int'(hiccup_cnt), c_e);
    end
  endtask

  task automatic go_idle(input string req);
    enable = 1'b0;
    @(negedge clk);
    chk({req, " ramp R10"}, int'(ramp_mv), 0);
    chk({req, " en R10"}, int'(rail_en_a | rail_en_b), 0);
    chk({req, " in_reg R10"}, int'(in_reg), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset ramp R1", int'(ramp_mv), 0);
    chk("reset en R1", int'(rail_en_a | rail_en_b), 0);
    chk("reset in_reg R1", int'(in_reg), 0);
    chk("reset cnt R1", int'(hiccup_cnt), 0);

    // Clean ramp, both rails tracking: every edge against the closed form
    trk_a = 1'b1; trk_b = 1'b1;
    enable = 1'b1;
    for (int n = 1; n <= NSTEPS * T + 8; n++) begin
      @(negedge clk);
      chk("ramp value R2", int'(ramp_mv), min2(REF, ((n - 1) / T) * STEP));
      chk("ramp bound R3", int'(ramp_mv <= REF), 1);
      chk("ramp en R2", int'(rail_en_a & rail_en_b), 1);
      chk("reg entry R7", int'(in_reg), (n >= 2 + NSTEPS * T) ? 1 : 0);
    end
    go_idle("after clean ramp");

    // Rail B shorted at 0: repeated hiccups, counter runs into saturation
    trk_b = 1'b0; cst_b = '0;
    enable = 1'b1;
    sweep_fault("short B", 10 * P);
    go_idle("after short B");
    chk("cnt kept in idle R9", int'(hiccup_cnt), CMAX);

    // Rail A shorted: one period, counter cleared at the new session
    trk_b = 1'b1; trk_a = 1'b0; cst_a = '0;
    enable = 1'b1;
    sweep_fault("short A R6", P + 4);
    go_idle("after short A");

    // Feedback below the window but not in fault: ramp waits at the target
    trk_a = 1'b0; trk_b = 1'b0;
    cst_a = CODE_W'(REF - TOL - 2); cst_b = CODE_W'(REF - TOL - 2);
    enable = 1'b1;
    for (int n = 1; n <= NSTEPS * T + 10; n++) @(negedge clk);
    chk("wait in_reg R7", int'(in_reg), 0);
    chk("wait ramp R3", int'(ramp_mv), REF);
    chk("wait en R7", int'(rail_en_a & rail_en_b), 1);
    chk("wait no hiccup R7", int'(hiccup_cnt), 0);
    cst_a = CODE_W'(REF - TOL);
    @(negedge clk);
    chk("one rail in window R7", int'(in_reg), 0);
    cst_b = CODE_W'(REF - TOL);
    @(negedge clk);
    chk("window edge R7", int'(in_reg), 1);

    // In regulation: a collapsed rail is ignored
    cst_a = '0;
    for (int n = 0; n < 40; n++) begin
      @(negedge clk);
      chk("reg hold R8", int'(in_reg), 1);
      chk("reg en R8", int'(rail_en_a & rail_en_b), 1);
      chk("reg ramp R8", int'(ramp_mv), REF);
      chk("reg cnt R8", int'(hiccup_cnt), 0);
    end
    go_idle("after regulation");

    // Enable removed partway through a ramp
    trk_a = 1'b1; trk_b = 1'b1;
    enable = 1'b1;
    repeat (4 * T + 1) @(negedge clk);
    chk("mid ramp R2", int'(ramp_mv), 4 * STEP);
    go_idle("mid ramp drop");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule